// File: doc/BRIEF.md
# Load/Store Address and Base Writeback Unit

This unit turns a word load or store instruction into a memory address, a new base-register value and three enables. It takes the base register value, a 12-bit immediate and a register offset, together with the two major-opcode bits and six function bits of the instruction. It adds or subtracts the selected offset from the base once. The result is then used as the address, as the writeback value, or as both, depending on the indexing mode.

Three indexing modes are supported. Offset mode accesses base plus or minus offset and leaves the base unchanged. Pre-index mode accesses the same address and writes it back to the base register. Post-index mode accesses the unmodified base and writes back base plus or minus offset. All outputs are registered, so they appear one clock after the instruction is presented. Alignment is not checked, and shifted offsets, byte and halfword accesses and the memory itself are outside the unit.

Top module: `lsu_agu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is zero after that edge.
- R2: Each output reflects the inputs sampled at the previous rising edge and nothing earlier (one cycle latency).
- R3: Offset mode (function bit 4 = 1, bit 1 = 0): `addr_o` is base ± offset, `wb_val_o` is the same value, and `wb_en_o` is 0.
- R4: Pre-index mode (function bit 4 = 1, bit 1 = 1): `addr_o` and `wb_val_o` are both base ± offset, and `wb_en_o` is 1.
- R5: Post-index mode (function bit 4 = 0, bit 1 either value): `addr_o` is the unmodified base, `wb_val_o` is base ± offset, and `wb_en_o` is 1.
- R6: Function bit 3 set adds the offset and clear subtracts it, modulo 2^32, with no alignment check.
- R7: Function bit 5 clear selects the 12-bit immediate, zero-extended. Set, it selects the full 32-bit register offset.
- R8: Function bit 0 set is a load (`ld_en_o` = 1, `mem_we_o` = 0). Clear, it is a store (`mem_we_o` = 1, `ld_en_o` = 0).
- R9: When `vld_i` is 0 or `op_i` is not 2'b01, all three enables are 0. Function bit 2 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vld_i | input | 1 | Instruction present this cycle |
| op_i | input | 2 | Major opcode; 2'b01 marks a load/store |
| funct_i | input | 6 | Function bits: 5 reg-offset, 4 pre, 3 up, 2 ignored, 1 writeback, 0 load |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset |
| roff_i | input | 32 | Register offset value |
| addr_o | output | 32 | Memory address |
| wb_val_o | output | 32 | New base register value |
| wb_en_o | output | 1 | Base writeback enable |
| mem_we_o | output | 1 | Memory write enable (store) |
| ld_en_o | output | 1 | Register load enable |

## Verification
The bench covers subtraction that borrows past zero and addition that carries past the top. An adder with the wrong carry-in or operand inversion would produce an address off by one or wrapped wrongly. It drives post-index with both writeback-bit values: a design that swapped the address and writeback muxes would issue the modified address, and one that read bit 1 in post-index would drop the base update. It also uses the largest immediate and register offsets with the top bit set, which expose sign-extension of the immediate or truncation of the register path. Idle and non-memory cycles, and the ignored byte bit, show up as stray enables or changed results.

// File: rtl/lsu_agu_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the load/store address unit.
// Assumes the caller passes function bits in the order the decode expects.
package lsu_agu_pkg;

    localparam logic [1:0] MEM_OP = 2'b01;

    localparam int F_REGOFF = 5;
    localparam int F_PRE    = 4;
    localparam int F_UP     = 3;
    localparam int F_WBACK  = 1;
    localparam int F_LOAD   = 0;

    typedef enum logic [1:0] {
        IDX_OFFSET = 2'd0,
        IDX_PRE    = 2'd1,
        IDX_POST   = 2'd2
    } idx_mode_e;

    typedef struct packed {
        logic      is_mem;
        logic      is_load;
        logic      use_reg;
        logic      add_dir;
        idx_mode_e mode;
    } lsu_ctrl_t;

endpackage

// File: rtl/lsu_agu_decode.sv
`timescale 1ns/1ps
// Module: lsu_agu_decode
// Turns opcode and function bits into a control struct.
// Assumes a word access; the byte-select bit is deliberately dropped.
module lsu_agu_decode
    import lsu_agu_pkg::*;
(
    input  logic       vld_i,
    input  logic [1:0] op_i,
    input  logic [5:0] funct_i,
    output lsu_ctrl_t  ctrl_o
);

    logic byte_sel_unused;
    assign byte_sel_unused = funct_i[2];

    // Decode the instruction fields into mode and direction controls.
    always_comb begin
        ctrl_o.is_mem  = vld_i && (op_i == MEM_OP);
        ctrl_o.is_load = funct_i[F_LOAD];
        ctrl_o.use_reg = funct_i[F_REGOFF];
        ctrl_o.add_dir = funct_i[F_UP];
        if (!funct_i[F_PRE])
            ctrl_o.mode = IDX_POST;
        else if (funct_i[F_WBACK])
            ctrl_o.mode = IDX_PRE;
        else
            ctrl_o.mode = IDX_OFFSET;
    end

endmodule

// File: rtl/lsu_agu_offset.sv
`timescale 1ns/1ps
// Module: lsu_agu_offset
// Selects between a zero-extended immediate and a register offset.
// Assumes IMM_W is no wider than needed; it truncates when IMM_W >= DATA_W.
module lsu_agu_offset #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic              use_reg_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] roff_i,
    output logic [DATA_W-1:0] off_o
);

    logic [DATA_W-1:0] imm_ext;

    generate
        if (DATA_W > IMM_W) begin : g_zext
            localparam int PAD_W = DATA_W - IMM_W;
            assign imm_ext = {{PAD_W{1'b0}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[DATA_W-1:0];
        end
    endgenerate

    // Choose the offset source.
    always_comb begin
        off_o = use_reg_i ? roff_i : imm_ext;
    end

endmodule

// File: rtl/lsu_agu_arith.sv
`timescale 1ns/1ps
// Module: lsu_agu_arith
// One adder computing base plus or minus offset, wrapping modulo 2^DATA_W.
// Subtraction uses inverted offset with carry-in, so no second adder is needed.
module lsu_agu_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] off_i,
    input  logic              add_dir_i,
    output logic [DATA_W-1:0] sum_o
);

    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] cin;

    // Form the conditioned operand and carry-in, then add.
    always_comb begin
        opnd  = add_dir_i ? off_i : ~off_i;
        cin   = {{(DATA_W-1){1'b0}}, ~add_dir_i};
        sum_o = base_i + opnd + cin;
    end

endmodule

// File: rtl/lsu_agu.sv
`timescale 1ns/1ps
// Module: lsu_agu (top)
// Produces the address, the base writeback value and the access enables,
// registered one cycle after the instruction. Alignment is not checked.
module lsu_agu
    import lsu_agu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [1:0]        op_i,
    input  logic [5:0]        funct_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] roff_i,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] wb_val_o,
    output logic              wb_en_o,
    output logic              mem_we_o,
    output logic              ld_en_o
);

    lsu_ctrl_t         ctrl;
    logic [DATA_W-1:0] off;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] addr_nxt;
    logic              wb_en_nxt;
    logic              we_nxt;
    logic              ld_nxt;

    lsu_agu_decode u_dec (
        .vld_i   (vld_i),
        .op_i    (op_i),
        .funct_i (funct_i),
        .ctrl_o  (ctrl)
    );

    lsu_agu_offset #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_off (
        .use_reg_i (ctrl.use_reg),
        .imm_i     (imm_i),
        .roff_i    (roff_i),
        .off_o     (off)
    );

    lsu_agu_arith #(.DATA_W(DATA_W)) u_arith (
        .base_i    (base_i),
        .off_i     (off),
        .add_dir_i (ctrl.add_dir),
        .sum_o     (sum)
    );

    // Pick the address source and the enables from the decoded mode.
    always_comb begin
        addr_nxt  = (ctrl.mode == IDX_POST) ? base_i : sum;
        wb_en_nxt = ctrl.is_mem && (ctrl.mode != IDX_OFFSET);
        we_nxt    = ctrl.is_mem && !ctrl.is_load;
        ld_nxt    = ctrl.is_mem && ctrl.is_load;
    end

    // Register all outputs with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o   <= '0;
            wb_val_o <= '0;
            wb_en_o  <= 1'b0;
            mem_we_o <= 1'b0;
            ld_en_o  <= 1'b0;
        end else begin
            addr_o   <= addr_nxt;
            wb_val_o <= sum;
            wb_en_o  <= wb_en_nxt;
            mem_we_o <= we_nxt;
            ld_en_o  <= ld_nxt;
        end
    end

endmodule

// File: rtl/lsu_agu_chk.sv
`timescale 1ns/1ps
// Module: lsu_agu_chk
// Temporal checks on the unit's ports; attached by bind below.
module lsu_agu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vld_i,
    input logic [1:0]        op_i,
    input logic              pre_i,
    input logic              wback_i,
    input logic [DATA_W-1:0] base_i,
    input logic [DATA_W-1:0] addr_o,
    input logic [DATA_W-1:0] wb_val_o,
    input logic              wb_en_o,
    input logic              mem_we_o,
    input logic              ld_en_o
);

    logic mem_now;
    assign mem_now = vld_i && (op_i == 2'b01);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 && wb_val_o == '0 && !wb_en_o && !mem_we_o && !ld_en_o));

    a_r8_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, ld_en_o}));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_now |=> (!wb_en_o && !mem_we_o && !ld_en_o));

    a_r5_post_base: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_now && !pre_i) |=> (wb_en_o && addr_o == $past(base_i)));

    a_r3_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_now && pre_i && !wback_i) |=> !wb_en_o);

    a_r4_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_now && pre_i && wback_i) |=> (wb_en_o && addr_o == wb_val_o));

endmodule

bind lsu_agu lsu_agu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (vld_i),
    .op_i     (op_i),
    .pre_i    (funct_i[4]),
    .wback_i  (funct_i[1]),
    .base_i   (base_i),
    .addr_o   (addr_o),
    .wb_val_o (wb_val_o),
    .wb_en_o  (wb_en_o),
    .mem_we_o (mem_we_o),
    .ld_en_o  (ld_en_o)
);

// File: tb/lsu_agu_tb.sv
`timescale 1ns/1ps
// Bench for lsu_agu: behavioural reference compared after every clock.
module lsu_agu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [5:0]  funct_i = 6'd0;
    logic [31:0] base_i = 32'd0;
    logic [11:0] imm_i = 12'd0;
    logic [31:0] roff_i = 32'd0;
    logic [31:0] addr_o, wb_val_o;
    logic        wb_en_o, mem_we_o, ld_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lsu_agu u_dut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i), .funct_i(funct_i),
        .base_i(base_i), .imm_i(imm_i), .roff_i(roff_i),
        .addr_o(addr_o), .wb_val_o(wb_val_o), .wb_en_o(wb_en_o),
        .mem_we_o(mem_we_o), .ld_en_o(ld_en_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, compare at the next one.
    task automatic step(input bit rs, input bit v, input logic [1:0] op,
                        input logic [5:0] f, input logic [31:0] b,
                        input logic [11:0] im, input logic [31:0] ro, input string tag);
        logic [31:0] e_addr, e_wb, offv;
        bit e_wen, e_we, e_ld, mem;
        rst_n = rs; vld_i = v; op_i = op; funct_i = f;
        base_i = b; imm_i = im; roff_i = ro;
        if (f[5]) offv = ro; else offv = {20'd0, im};
        if (f[3]) e_wb = b + offv; else e_wb = b - offv;
        mem = v && (op == 2'b01);
        if (!f[4]) begin e_addr = b; e_wen = mem; end
        else if (f[1]) begin e_addr = e_wb; e_wen = mem; end
        else begin e_addr = e_wb; e_wen = 0; end
        e_we = mem && !f[0];
        e_ld = mem && f[0];
        if (!rs) begin e_addr = 0; e_wb = 0; e_wen = 0; e_we = 0; e_ld = 0; end
        @(negedge clk);
        chk(tag, "addr", addr_o, e_addr);
        chk(tag, "wb_val", wb_val_o, e_wb);
        chk(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, e_wen});
        chk(tag, "mem_we", {31'd0, mem_we_o}, {31'd0, e_we});
        chk(tag, "ld_en", {31'd0, ld_en_o}, {31'd0, e_ld});
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        @(negedge clk);
        // R1: reset with busy inputs forces zeros
        step(0, 1, 2'b01, 6'b011010, 32'h1234, 12'h10, 32'h5, "R1");
        step(0, 1, 2'b01, 6'b001001, 32'hFFFF, 12'hFFF, 32'h5, "R1");
        // R3 offset mode, add load and subtract store
        step(1, 1, 2'b01, 6'b011001, 32'h1000, 12'h024, 32'h0, "R3");
        step(1, 1, 2'b01, 6'b010000, 32'h1000, 12'h010, 32'h0, "R3");
        // R4 pre-index, immediate add store and register subtract load
        step(1, 1, 2'b01, 6'b011010, 32'h2000, 12'h008, 32'h0, "R4");
        step(1, 1, 2'b01, 6'b110011, 32'h2000, 12'h000, 32'h100, "R4");
        // R5 post-index with writeback bit clear and set
        step(1, 1, 2'b01, 6'b001001, 32'h3000, 12'h004, 32'h0, "R5");
        step(1, 1, 2'b01, 6'b100000, 32'h3000, 12'h000, 32'h40, "R5");
        step(1, 1, 2'b01, 6'b001011, 32'h3000, 12'h00C, 32'h0, "R5");
        // R6 wraparound in both directions
        step(1, 1, 2'b01, 6'b011001, 32'hFFFF_FFF0, 12'h020, 32'h0, "R6");
        step(1, 1, 2'b01, 6'b010001, 32'h0000_0008, 12'h010, 32'h0, "R6");
        step(1, 1, 2'b01, 6'b011011, 32'h0000_0003, 12'h001, 32'h0, "R6");
        // R7 largest immediate and top-bit register offset
        step(1, 1, 2'b01, 6'b011001, 32'h0, 12'hFFF, 32'hFFFF_FFFF, "R7");
        step(1, 1, 2'b01, 6'b010001, 32'h0, 12'hFFF, 32'h0, "R7");
        step(1, 1, 2'b01, 6'b111000, 32'h1, 12'h000, 32'h8000_0000, "R7");
        // R8 load and store enables
        step(1, 1, 2'b01, 6'b011000, 32'h40, 12'h4, 32'h0, "R8");
        step(1, 1, 2'b01, 6'b011001, 32'h40, 12'h4, 32'h0, "R8");
        // R9 idle, non-memory opcodes, byte bit ignored
        step(1, 0, 2'b01, 6'b011011, 32'h50, 12'h4, 32'h0, "R9");
        step(1, 1, 2'b00, 6'b001001, 32'h50, 12'h4, 32'h0, "R9");
        step(1, 1, 2'b10, 6'b011010, 32'h50, 12'h4, 32'h0, "R9");
        step(1, 1, 2'b01, 6'b011101, 32'h50, 12'h4, 32'h0, "R9");
        step(1, 1, 2'b01, 6'b000110, 32'h50, 12'h4, 32'h0, "R9");
        // R2 back-to-back random stream, one-cycle latency each cycle
        for (int i = 0; i < 400; i++) begin
            step(1, 1'($urandom), 2'($urandom), 6'($urandom), $urandom,
                 12'($urandom), $urandom, "R2");
        end
        // R1 reset again mid-stream
        step(0, 1, 2'b01, 6'b001000, 32'h77, 12'h1, 32'h0, "R1");
        step(1, 1, 2'b01, 6'b001000, 32'h77, 12'h1, 32'h0, "R5");
        report();
    end

endmodule